// File: doc/BRIEF.md
# Decimate-by-Twenty Low-Pass Filter

This block is a real-valued low-pass FIR filter that reduces the sample rate as it filters. A signed sample arrives on every clock edge of the fast clock, and an external output-rate enable pulses once per decimation period. The filter evaluates only the convolution results that survive decimation: one result per period. It divides the 120 fixed taps into twenty phase groups. A chain of six partial sums is updated for every input sample, so no delay line of past inputs is kept.

The enable pulse defines the phase. The sample taken on a pulse edge is the newest term of the output that completes on that edge. Samples that arrive after reset but before the first pulse are discarded. The result completed on the first pulse is also withheld, so every presented output covers at least one full period of input. Each completed sum is divided by a power of two, using an arithmetic right shift, and then held on the output until the next result.

Top module: `poly_decim_fir`

## Requirements
- R1: Reset is active-low and synchronous. While it is sampled low, the next edge clears `dout` to 0 and `dout_valid` to 0.
- R2: The tap values are h[k] = ((173*k + 29) mod 4001) - 2000 for k = 0..119, each held as a signed 16-bit constant.
- R3: After reset, the input samples before the first `slow_en` edge have no effect on any later output.
- R4: The sample on the first `slow_en` edge after reset is x[0], and every later edge supplies the next index. With x of a negative index taken as 0, the result for the pulse that takes x[20m] is y[20m] = sum over k of h[k]*x[20m-k].
- R5: `dout_valid` is high for exactly the one cycle after each `slow_en` edge, except after the first `slow_en` edge following reset.
- R6: `dout` equals y[20m] shifted right arithmetically by 8, which rounds toward minus infinity. It is presented as a 27-bit two's-complement value.
- R7: `dout` does not change in any cycle where `dout_valid` is low.
- R8: A constant full-scale input of -2048 or +2047 gives exact results, with no wrap-around.
- R9: One sample taken on a `slow_en` edge both completes the current output and starts the five outputs that follow it. An impulse therefore appears in six consecutive outputs, scaled by h[0], h[20], ..., h[100].
- R10: `slow_en` is expected every 20 cycles. Each pulse restarts the phase count, so the sample one cycle after a pulse uses tap group 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_en | input | 1 | Output-rate enable, one cycle per decimation period |
| din | input | 12 | Signed input sample, taken on every edge |
| dout | output | 27 | Signed scaled result, held between updates |
| dout_valid | output | 1 | Pulses in the cycle after a `slow_en` edge that yields a result |

## Verification
The sample taken on a `slow_en` edge does two jobs in the same edge. It closes the output that leaves on that edge, and it seeds the five partial sums that shift forward. This is provoked with impulses: one placed exactly on a pulse edge, and one placed in the middle of a period. The outputs are then compared against a direct convolution in the bench. A boundary impulse must show up in six successive results with the tap-0 through tap-100 weights. The mid-period impulse must not leak into the result that closes before it.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

    // Fixed tap set, computed rather than tabulated.
    function automatic int coef_value(input int k);
        return ((k * 173 + 29) % 4001) - 2000;
    endfunction

endpackage

// File: rtl/pdf_phase_seq.sv
module pdf_phase_seq #(
    parameter int DECIM = 20,
    parameter int PH_W  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slow_en,
    output logic [PH_W-1:0] phase_o,
    output logic            accept_o,
    output logic            emit_o
);

    typedef struct packed {
        logic [PH_W-1:0] cnt;
        logic            locked;
        logic            primed;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (slow_en) begin
            s_d.cnt    = (DECIM > 1) ? PH_W'(1) : '0;
            s_d.locked = 1'b1;
            s_d.primed = 1'b1;
        end else if (s_q.locked) begin
            s_d.cnt = (s_q.cnt == PH_W'(DECIM - 1)) ? '0 : s_q.cnt + PH_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign phase_o  = slow_en ? '0 : s_q.cnt;
    assign accept_o = slow_en | s_q.locked;
    assign emit_o   = slow_en & s_q.primed;

endmodule

// File: rtl/pdf_tap_bank.sv
module pdf_tap_bank #(
    parameter int DECIM  = 20,
    parameter int SLOTS  = 6,
    parameter int PH_W   = 5,
    parameter int IN_W   = 12,
    parameter int COEF_W = 16,
    parameter int PROD_W = 28
) (
    input  logic signed [IN_W-1:0]   sample_i,
    input  logic        [PH_W-1:0]   phase_i,
    output logic signed [PROD_W-1:0] prod_o [SLOTS]
);

    logic [PH_W-1:0] grp;

    // Phase c feeds tap group (DECIM - c) mod DECIM.
    always_comb begin
        grp = (phase_i == '0) ? '0 : PH_W'(DECIM) - phase_i;
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic signed [COEF_W-1:0] coef;
        always_comb begin
            coef      = COEF_W'(pdf_pkg::coef_value(int'(grp) + DECIM * i));
            prod_o[i] = PROD_W'(sample_i) * PROD_W'(coef);
        end
    end

endmodule

// File: rtl/pdf_acc_chain.sv
module pdf_acc_chain #(
    parameter int SLOTS  = 6,
    parameter int PROD_W = 28,
    parameter int ACC_W  = 35
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     accept_i,
    input  logic                     boundary_i,
    input  logic signed [PROD_W-1:0] prod_i [SLOTS],
    output logic signed [ACC_W-1:0]  total_o
);

    typedef struct packed {
        logic [SLOTS-1:0][ACC_W-1:0] acc;
    } chain_t;

    chain_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (accept_i) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (boundary_i) begin
                    if (i == SLOTS - 1) c_d.acc[i] = '0;
                    else c_d.acc[i] = $signed(c_q.acc[i+1]) + ACC_W'(prod_i[i+1]);
                end else begin
                    c_d.acc[i] = $signed(c_q.acc[i]) + ACC_W'(prod_i[i]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign total_o = $signed(c_q.acc[0]) + ACC_W'(prod_i[0]);

endmodule

// File: rtl/poly_decim_fir.sv
module poly_decim_fir #(
    parameter int IN_W       = 12,
    parameter int COEF_W     = 16,
    parameter int NUM_TAPS   = 120,
    parameter int DECIM      = 20,
    parameter int NORM_SHIFT = 8,
    parameter int OUT_W      = IN_W + COEF_W + $clog2(NUM_TAPS) - NORM_SHIFT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   slow_en,
    input  logic signed [IN_W-1:0] din,
    output logic [OUT_W-1:0]       dout,
    output logic                   dout_valid
);

    localparam int SLOTS  = NUM_TAPS / DECIM;
    localparam int PH_W   = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam int PROD_W = IN_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(NUM_TAPS);

    logic [PH_W-1:0]           phase;
    logic                      accept;
    logic                      emit;
    logic signed [PROD_W-1:0]  prod [SLOTS];
    logic signed [ACC_W-1:0]   total;

    pdf_phase_seq #(.DECIM(DECIM), .PH_W(PH_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en),
        .phase_o(phase), .accept_o(accept), .emit_o(emit)
    );

    pdf_tap_bank #(
        .DECIM(DECIM), .SLOTS(SLOTS), .PH_W(PH_W),
        .IN_W(IN_W), .COEF_W(COEF_W), .PROD_W(PROD_W)
    ) u_taps (
        .sample_i(din), .phase_i(phase), .prod_o(prod)
    );

    pdf_acc_chain #(.SLOTS(SLOTS), .PROD_W(PROD_W), .ACC_W(ACC_W)) u_chain (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .boundary_i(slow_en),
        .prod_i(prod), .total_o(total)
    );

    typedef struct packed {
        logic [OUT_W-1:0] data;
        logic             valid;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d       = o_q;
        o_d.valid = emit;
        if (emit) o_d.data = OUT_W'(total >>> NORM_SHIFT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign dout       = o_q.data;
    assign dout_valid = o_q.valid;

endmodule

// File: rtl/pdf_checker.sv
module pdf_checker #(
    parameter int OUT_W = 27
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slow_en,
    input logic             dout_valid,
    input logic [OUT_W-1:0] dout
);

    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n)       seen_q <= 1'b0;
        else if (slow_en) seen_q <= 1'b1;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!dout_valid && dout == '0));

    // R5
    valid_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> $past(slow_en));

    // R5
    first_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_en && !seen_q) |=> !dout_valid);

    // R7
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_valid |-> $stable(dout));

endmodule

bind poly_decim_fir pdf_checker #(.OUT_W(OUT_W)) u_pdf_checker (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en),
    .dout_valid(dout_valid), .dout(dout)
);

// File: tb/poly_decim_fir_bench.sv
module poly_decim_fir_bench;

    localparam int OUT_W = 27;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    slow_en = 1'b0;
    logic signed [11:0]      din = '0;
    logic [OUT_W-1:0]        dout;
    logic                    dout_valid;

    int     checks = 0;
    int     errors = 0;
    longint hist [0:4095];
    int     n_s = 0;
    bit     locked = 0;
    bit     primed = 0;
    longint last_out = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    poly_decim_fir u_poly_decim_fir (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .din(din),
        .dout(dout), .dout_valid(dout_valid)
    );

    function automatic longint h(input int k);
        return longint'(((k * 173 + 29) % 4001) - 2000);
    endfunction

    function automatic longint exp_y(input int idx);
        longint s = 0;
        for (int k = 0; k < 120; k++)
            if (idx - k >= 0) s += h(k) * hist[idx - k];
        return s >>> 8;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; din = '0; slow_en = 0;
        repeat (3) @(negedge clk);
        check("R1 dout_valid", longint'(dout_valid), 0);
        check("R1 dout", longint'($signed(dout)), 0);
        rst_n = 1;
        n_s = 0; locked = 0; primed = 0; last_out = 0;
    endtask

    task automatic step(input logic signed [11:0] x, input logic se, input string tag);
        bit exp_v;
        din = x; slow_en = se;
        @(posedge clk);
        if (se || locked) begin
            hist[n_s] = longint'(x);
            n_s++;
            locked = 1;
        end
        exp_v = se && primed;
        if (se) primed = 1;
        @(negedge clk);
        check("R5 valid", longint'(dout_valid), longint'(exp_v));
        if (exp_v) begin
            last_out = exp_y(n_s - 1);
            check(tag, longint'($signed(dout)), last_out);
        end else begin
            check("R7 hold", longint'($signed(dout)), last_out);
        end
    endtask

    // mode 0: pseudo-random, 1: two impulses, 2: constant
    task automatic run_seg(input int pre, input int ncyc, input int mode,
                           input int cval, input string tag);
        logic signed [11:0] x;
        for (int i = 0; i < pre; i++) step(12'sd2047, 1'b0, "R3");
        for (int i = 0; i < ncyc; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (mode)
                0:       x = lfsr[11:0];
                1:       x = (i == 40 || i == 67) ? 12'(cval) : 12'sd0;
                default: x = 12'(cval);
            endcase
            step(x, (i % 20) == 0, tag);
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        run_seg(7, 400, 0, 0, "R3 R4 R6 R10");
        do_reset();
        run_seg(0, 200, 1, 1000, "R2 R9");
        do_reset();
        run_seg(3, 200, 1, -1500, "R2 R9 R6");
        do_reset();
        run_seg(0, 180, 2, -2048, "R8 neg");
        do_reset();
        run_seg(0, 180, 2, 2047, "R8 pos");
        do_reset();
        run_seg(5, 300, 0, 0, "R4 R6 R10");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule